// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block owns the row strobe, column strobe and write-enable lines of an asynchronous DRAM whenever the memory needs housekeeping. After a synchronous reset it holds every strobe high for a fixed start-up delay. It then runs a back-to-back train of column-before-row refresh cycles and only afterwards raises `ready`. Until `ready` is high, no normal access may touch the memory.

In normal operation an interval timer adds one refresh request at a fixed period. Requests accumulate in a small saturating counter, so a refresh that arrives while a long page-mode access holds the bus is kept. While requests are waiting and the sequencer is idle, it raises `req`. When the access arbiter answers with `gnt`, the sequencer takes the strobes and runs one refresh cycle:

- precharge,
- column strobe low,
- row strobe low,
- precharge again.

It then hands the strobes back. Write-enable stays high throughout, so no refresh cycle can be mistaken for a test-mode entry.

All timing minimums are parameters counted in system clock cycles. Their defaults are derived from nanosecond figures at an 8 ns clock, rounding up.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is high and for STARTUP_CYC clock cycles after it is released, ras_n, cas_n and we_n are 1, ready is 0, req is 0 and busy is 1.
- R2: After the start-up delay, INIT_CNT refresh cycles run back to back without any grant. Each cycle is T_CSR_CYC + max(T_RAS_CYC, T_CHR_CYC) + T_RP_CYC clocks long. At the end of the last cycle ready becomes 1, and it stays 1 until the next reset.
- R3: In every refresh cycle, cas_n goes low exactly T_CSR_CYC cycles before ras_n goes low. cas_n stays low for all of the row-low time. ras_n stays low for exactly max(T_RAS_CYC, T_CHR_CYC) cycles. Both strobes then return to 1 in the same cycle.
- R4: we_n is 1 in every cycle.
- R5: Before every falling edge of ras_n, ras_n has been 1 for at least T_RP_CYC cycles. A granted refresh starts with T_RP_CYC cycles in which both strobes are 1.
- R6: Once ready is 1, one refresh request is added every INTERVAL_CYC cycles.
- R7: The number of pending requests saturates at PEND_MAX. req is 1 exactly when at least one request is pending, ready is 1 and the strobes are not owned (busy is 0).
- R8: A refresh starts only in a cycle where req and gnt are both 1 at the clock edge. busy is 1 from the following cycle until the final precharge ends. When busy is 0, ras_n and cas_n are 1.
- R9: Each granted refresh removes one pending request. A timer tick in the same cycle as a grant leaves the count unchanged.
- R10: ras_n is never low for RAS_MAX_CYC cycles or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| gnt | input | 1 | Arbiter grant of the strobe lines, acted on only while req is 1 |
| req | output | 1 | Refresh wanted and strobes free to hand over |
| busy | output | 1 | Sequencer owns the strobe lines (includes power-up) |
| ready | output | 1 | Initialization complete, normal accesses allowed |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |

## Verification
The checker watches every cycle for the following:

- the column-to-row lead on each row-strobe fall,
- the precharge gap before each fall,
- the row-low width and its upper bound,
- column strobe staying low under a low row strobe,
- quiet strobes while busy is low,
- no cycle starting without a grant,
- ready never falling.

Only the bench scenarios can show the rest: the exact power-up length, the interval between requests, the saturation of pending requests after a long withheld grant, and the count of refreshes served once the grant returns. These depend on counts accumulated across hundreds of cycles.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_PWR,
        ST_IDLE,
        ST_PRE,
        ST_CSR,
        ST_RAS,
        ST_POST
    } seq_state_t;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    localparam strobe_t STROBE_QUIET = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // round a nanosecond minimum up to whole clock periods
    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // strobe levels belonging to each sequencer state
    function automatic strobe_t strobe_of(input seq_state_t s);
        strobe_t o;
        o.ras_n = (s != ST_RAS);
        o.cas_n = !((s == ST_CSR) || (s == ST_RAS));
        o.we_n  = 1'b1;
        return o;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int INTERVAL_CYC = 1950
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int W = $clog2(INTERVAL_CYC + 1);

    logic [W-1:0] cnt;

    assign tick = en && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= W'(INTERVAL_CYC - 1);
        end else if (en) begin
            if (cnt == '0) cnt <= W'(INTERVAL_CYC - 1);
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/rfsh_pending.sv
module rfsh_pending #(
    parameter int PEND_MAX = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic inc,
    input  logic dec,
    output logic nonzero
);
    localparam int W = $clog2(PEND_MAX + 1);

    logic [W-1:0] cnt;

    assign nonzero = (cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (cnt != W'(PEND_MAX)) cnt <= cnt + 1'b1;
                2'b01:   if (cnt != '0)           cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/rfsh_strobe_fsm.sv
module rfsh_strobe_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int STARTUP_CYC = 25000,
    parameter int INIT_CNT    = 8,
    parameter int T_CSR_CYC   = 2,
    parameter int T_CHR_CYC   = 3,
    parameter int T_RAS_CYC   = 8,
    parameter int T_RP_CYC    = 5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output strobe_t strobe,
    output logic    busy,
    output logic    idle,
    output logic    ready
);
    localparam int RAS_LOW = max2(T_RAS_CYC, T_CHR_CYC);
    localparam int LONGEST = max2(max2(STARTUP_CYC, RAS_LOW), max2(T_RP_CYC, T_CSR_CYC));
    localparam int CW      = $clog2(LONGEST + 1);
    localparam int IW      = $clog2(INIT_CNT + 1);

    seq_state_t   st, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic [IW-1:0] icnt, icnt_nxt;
    logic          ready_q, ready_nxt;
    logic          last;

    function automatic logic [CW-1:0] span(input seq_state_t s);
        case (s)
            ST_PWR:  return CW'(STARTUP_CYC - 1);
            ST_PRE:  return CW'(T_RP_CYC - 1);
            ST_CSR:  return CW'(T_CSR_CYC - 1);
            ST_RAS:  return CW'(RAS_LOW - 1);
            ST_POST: return CW'(T_RP_CYC - 1);
            default: return '0;
        endcase
    endfunction

    assign last = (cnt == '0);

    always_comb begin
        nxt       = st;
        icnt_nxt  = icnt;
        ready_nxt = ready_q;
        case (st)
            ST_PWR: if (last) begin
                nxt      = ST_CSR;
                icnt_nxt = IW'(INIT_CNT - 1);
            end
            ST_IDLE: if (start) nxt = ST_PRE;
            ST_PRE:  if (last) nxt = ST_CSR;
            ST_CSR:  if (last) nxt = ST_RAS;
            ST_RAS:  if (last) nxt = ST_POST;
            ST_POST: if (last) begin
                if (!ready_q && (icnt != '0)) begin
                    icnt_nxt = icnt - 1'b1;
                    nxt      = ST_CSR;
                end else begin
                    nxt       = ST_IDLE;
                    ready_nxt = 1'b1;
                end
            end
            default: nxt = ST_IDLE;
        endcase

        if (nxt != st)     cnt_nxt = span(nxt);
        else if (!last)    cnt_nxt = cnt - 1'b1;
        else               cnt_nxt = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_PWR;
            cnt     <= span(ST_PWR);
            icnt    <= '0;
            ready_q <= 1'b0;
            strobe  <= STROBE_QUIET;
        end else begin
            st      <= nxt;
            cnt     <= cnt_nxt;
            icnt    <= icnt_nxt;
            ready_q <= ready_nxt;
            strobe  <= strobe_of(nxt);
        end
    end

    assign busy  = (st != ST_IDLE);
    assign idle  = (st == ST_IDLE);
    assign ready = ready_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int CLK_PS       = 8000,
    parameter int STARTUP_CYC  = ns_to_cyc(200000, CLK_PS),
    parameter int INTERVAL_CYC = ns_to_cyc(15600, CLK_PS),
    parameter int INIT_CNT     = 8,
    parameter int PEND_MAX     = 4,
    parameter int T_CSR_CYC    = ns_to_cyc(10, CLK_PS),
    parameter int T_CHR_CYC    = ns_to_cyc(20, CLK_PS),
    parameter int T_RAS_CYC    = ns_to_cyc(60, CLK_PS),
    parameter int T_RP_CYC     = ns_to_cyc(40, CLK_PS),
    parameter int RAS_MAX_CYC  = ns_to_cyc(10000, CLK_PS)
) (
    input  logic clk,
    input  logic rst,
    input  logic gnt,
    output logic req,
    output logic busy,
    output logic ready,
    output logic ras_n,
    output logic cas_n,
    output logic we_n
);
    logic    tick;
    logic    pending;
    logic    idle;
    logic    start;
    strobe_t strobe;

    assign req   = pending && idle;
    assign start = req && gnt;

    rfsh_interval_timer #(
        .INTERVAL_CYC(INTERVAL_CYC)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .en  (ready),
        .tick(tick)
    );

    rfsh_pending #(
        .PEND_MAX(PEND_MAX)
    ) u_pending (
        .clk    (clk),
        .rst    (rst),
        .inc    (tick),
        .dec    (start),
        .nonzero(pending)
    );

    rfsh_strobe_fsm #(
        .STARTUP_CYC(STARTUP_CYC),
        .INIT_CNT   (INIT_CNT),
        .T_CSR_CYC  (T_CSR_CYC),
        .T_CHR_CYC  (T_CHR_CYC),
        .T_RAS_CYC  (T_RAS_CYC),
        .T_RP_CYC   (T_RP_CYC)
    ) u_fsm (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .strobe(strobe),
        .busy  (busy),
        .idle  (idle),
        .ready (ready)
    );

    assign ras_n = strobe.ras_n;
    assign cas_n = strobe.cas_n;
    assign we_n  = strobe.we_n;
endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
    parameter int T_CSR_CYC   = 2,
    parameter int T_RAS_CYC   = 8,
    parameter int T_RP_CYC    = 5,
    parameter int RAS_MAX_CYC = 1250
) (
    input logic clk,
    input logic rst,
    input logic gnt,
    input logic req,
    input logic busy,
    input logic ready,
    input logic ras_n,
    input logic cas_n
);
    localparam int SAT = 1 << 30;

    int lead_cnt;
    int hi_cnt;
    int lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lead_cnt <= 0;
            hi_cnt   <= 0;
            lo_cnt   <= 0;
        end else begin
            if (cas_n)            lead_cnt <= 0;
            else if (ras_n && lead_cnt < SAT) lead_cnt <= lead_cnt + 1;
            if (ras_n) begin
                lo_cnt <= 0;
                if (hi_cnt < SAT) hi_cnt <= hi_cnt + 1;
            end else begin
                hi_cnt <= 0;
                if (lo_cnt < SAT) lo_cnt <= lo_cnt + 1;
            end
        end
    end

    // R3
    cas_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (lead_cnt >= T_CSR_CYC));
    // R3
    cas_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> !cas_n);
    // R3
    ras_width_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (lo_cnt >= T_RAS_CYC));
    // R10
    ras_max_chk: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> (lo_cnt < RAS_MAX_CYC));
    // R5
    precharge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi_cnt >= T_RP_CYC));
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ras_n && cas_n));
    // R8
    no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !gnt) |=> !busy);
    // R2
    ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);
    // R7
    req_ready_chk: assert property (@(posedge clk) disable iff (rst)
        req |-> (ready && !busy));
endmodule

bind dram_refresh_seq rfsh_seq_chk #(
    .T_CSR_CYC  (T_CSR_CYC),
    .T_RAS_CYC  (T_RAS_CYC),
    .T_RP_CYC   (T_RP_CYC),
    .RAS_MAX_CYC(RAS_MAX_CYC)
) i_chk (
    .clk  (clk),
    .rst  (rst),
    .gnt  (gnt),
    .req  (req),
    .busy (busy),
    .ready(ready),
    .ras_n(ras_n),
    .cas_n(cas_n)
);

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
    localparam int S    = 200;
    localparam int IV   = 100;
    localparam int NI   = 8;
    localparam int PM   = 3;
    localparam int TC   = 2;
    localparam int TH   = 3;
    localparam int TR   = 8;
    localparam int TP   = 5;
    localparam int RMAX = 1250;
    localparam int RL   = (TR > TH) ? TR : TH;
    localparam int L    = TC + RL + TP;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic gnt = 1'b0;
    logic req, busy, ready, ras_n, cas_n, we_n;

    always #4 clk = ~clk;

    dram_refresh_seq #(
        .STARTUP_CYC (S),
        .INTERVAL_CYC(IV),
        .INIT_CNT    (NI),
        .PEND_MAX    (PM),
        .T_CSR_CYC   (TC),
        .T_CHR_CYC   (TH),
        .T_RAS_CYC   (TR),
        .T_RP_CYC    (TP),
        .RAS_MAX_CYC (RMAX)
    ) i_dram_refresh_seq (
        .clk(clk), .rst(rst), .gnt(gnt), .req(req), .busy(busy),
        .ready(ready), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // behavioural reference: phase 0 power-up, 1 init train, 2 idle, 3 granted refresh
    int m_phase, m_pos, m_pend, m_rc;
    bit m_ready;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_pos = 0; m_pend = 0; m_rc = 0; m_ready = 1'b0;
        end else begin
            bit g, t;
            g = (m_phase == 2) && (m_pend > 0) && gnt;
            t = 1'b0;
            if (m_ready) begin
                m_rc++;
                if (m_rc % IV == 0) t = 1'b1;
            end
            case (m_phase)
                0: begin m_pos++; if (m_pos == S) begin m_phase = 1; m_pos = 0; end end
                1: begin m_pos++; if (m_pos == NI * L) begin m_phase = 2; m_pos = 0; m_ready = 1'b1; end end
                2: if (g) begin m_phase = 3; m_pos = 0; end
                default: begin m_pos++; if (m_pos == TP + L) begin m_phase = 2; m_pos = 0; end end
            endcase
            m_pend = m_pend - int'(g) + int'(t);
            if (m_pend > PM) m_pend = PM;
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit er, ec, eb, ery, erq;
            int q;
            er = 1'b1; ec = 1'b1; eb = 1'b1; ery = m_ready; erq = 1'b0;
            q  = -1;
            if (m_phase == 1)      q = m_pos % L;
            else if (m_phase == 3) q = m_pos - TP;
            if (q >= 0) begin
                ec = !(q < TC + RL);
                er = !((q >= TC) && (q < TC + RL));
            end
            if (m_phase == 2) begin
                eb  = 1'b0;
                erq = (m_pend > 0);
            end
            chk(ras_n === er,  "R3", "ras_n", int'(ras_n), int'(er));
            chk(cas_n === ec,  "R3", "cas_n", int'(cas_n), int'(ec));
            chk(we_n  === 1'b1, "R4", "we_n", int'(we_n), 1);
            chk(ready === ery, "R2", "ready", int'(ready), int'(ery));
            chk(req   === erq, "R7", "req",   int'(req),   int'(erq));
            chk(busy  === eb,  "R8", "busy",  int'(busy),  int'(eb));
        end
    end

    // edge separation monitor
    int hi_c, lo_c, lead_c, nfall;
    bit prev_ras;
    initial nfall = 0;

    always @(negedge clk) begin
        if (rst) begin
            hi_c = 0; lo_c = 0; lead_c = 0; prev_ras = 1'b1;
        end else if (!done) begin
            if (prev_ras && !ras_n) begin
                nfall++;
                chk(lead_c == TC, "R3", "cas lead before ras fall", lead_c, TC);
                chk(hi_c >= TP,   "R5", "precharge before ras fall", hi_c, TP);
            end
            if (!prev_ras && ras_n) begin
                chk(lo_c == RL,  "R3", "ras low width", lo_c, RL);
                chk(lo_c < RMAX, "R10", "ras low below max", lo_c, RMAX);
            end
            if (cas_n)      lead_c = 0;
            else if (ras_n) lead_c++;
            if (ras_n) begin hi_c++; lo_c = 0; end
            else       begin lo_c++; hi_c = 0; end
            prev_ras = ras_n;
        end
    end

    task automatic reset_and_bringup();
        int c;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ras_n === 1'b1, "R1", "ras_n in reset", int'(ras_n), 1);
        chk(cas_n === 1'b1, "R1", "cas_n in reset", int'(cas_n), 1);
        chk(we_n  === 1'b1, "R1", "we_n in reset",  int'(we_n),  1);
        chk(ready === 1'b0, "R1", "ready in reset", int'(ready), 0);
        chk(req   === 1'b0, "R1", "req in reset",   int'(req),   0);
        chk(busy  === 1'b1, "R1", "busy in reset",  int'(busy),  1);
        rst = 1'b0;
        c = 0;
        while (!ready && c < 5000) begin @(negedge clk); c++; end
        // R2 ready after delay plus init train
        chk(c == S + NI * L, "R2", "cycles until ready", c, S + NI * L);
    endtask

    task automatic wait_req_rise();
        while (req) @(negedge clk);
        while (!req) @(negedge clk);
    endtask

    initial begin
        int t1, t2, f0;
        reset_and_bringup();

        // R6 interval between requests with grant always given
        gnt = 1'b1;
        wait_req_rise();
        t1 = 0;
        wait_req_rise_count(t1);
        chk(t1 == IV, "R6", "cycles between requests", t1, IV);

        // R8 each request served once with grant held
        f0 = nfall;
        repeat (300) @(negedge clk);
        chk(nfall - f0 == 3, "R8", "refreshes in 300 cycles", nfall - f0, 3);

        // R7 saturation while grant withheld
        wait_req_rise();
        gnt = 1'b0;
        repeat (305) @(negedge clk);
        chk(req === 1'b1, "R7", "req held while pending", int'(req), 1);
        chk(busy === 1'b0, "R8", "no refresh without grant", int'(busy), 0);
        f0 = nfall;
        gnt = 1'b1;
        repeat (90) @(negedge clk);
        chk(nfall - f0 == PM, "R7", "refreshes after saturation", nfall - f0, PM);
        // R9 every grant consumed one request
        chk(req === 1'b0, "R9", "req after pending drained", int'(req), 0);

        // random grant pattern
        for (int i = 0; i < 3000; i++) begin
            gnt = ($urandom_range(0, 3) == 0);
            @(negedge clk);
        end
        gnt = 1'b0;

        // R1 second reset mid-operation
        reset_and_bringup();
        gnt = 1'b1;
        t2 = 0;
        repeat (250) @(negedge clk);
        chk(ready === 1'b1, "R2", "ready stays high", int'(ready), 1);

        done = 1'b1;
        finish_run();
    end

    task automatic wait_req_rise_count(output int n);
        n = 0;
        while (req) begin @(negedge clk); n++; end
        while (!req) begin @(negedge clk); n++; end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R8 watchdog expired: actual 0 expected 1");
            finish_run();
        end
    end
endmodule